// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of trace words into a circular on-chip RAM so that the activity around an event of interest can be read back afterwards. Software clears the write pointer, loads a post-trigger word count and sets the enable bit. From then on every valid trace word passes through a small two-entry holding stage and lands in the RAM at the write pointer, which wraps around the buffer. A trigger input marks the event. After the trigger word, the block keeps exactly the programmed number of further words and then stops taking input. The trigger's position in the captured window is therefore set by that count.

Completion and draining are reported separately. The done flag rises as soon as the last word has been accepted. The formatter-empty flag rises once that word has actually been written to the RAM. When the wrap flag is set, the oldest word sits at the write pointer; otherwise the valid words run from address 0 up to the write pointer minus one. Readout goes through a data register. Each read of it returns the word at the read pointer and then advances that pointer.

Top module: `cap_trace_buf`

## Requirements
- R1: After reset the control register, read pointer, write pointer and trigger counter read 0, the status register reads 8 (only formatter-empty set), and the status outputs match.
- R2: The register map uses a 3-bit address: 0 control, 1 status, 2 depth, 3 width, 4 read pointer, 5 write pointer, 6 trigger counter, 7 RAM data. Read data appears on `bus_rdata` in the cycle after `bus_rd`. Depth and width return the DEPTH and TRACE_W parameters, and writes to them have no effect.
- R3: Control bit 0 enables capture, and writing 0 to it stops capture. While it is 0, valid trace words are not stored and the write pointer does not move. Control bit 1 selects demultiplexed mode. It is kept only when TRACE_W is 8 and otherwise reads back 0.
- R4: Each accepted word is written to the RAM at the write pointer, and the pointer then advances by one modulo DEPTH.
- R5: Status bit 0 (full) is set when the write pointer wraps from DEPTH-1 to 0. It stays set until software writes the write pointer, which clears it.
- R6: Status bit 1 (triggered) is set when `trigger_in` is high together with a word that is accepted while enabled and not yet triggered.
- R7: After the trigger word, exactly N further words are accepted, where N is the trigger counter value at the trigger. The counter counts down once per accepted word. Status bit 2 (done) is then set, the counter reads 0, and later trace words are ignored.
- R8: Status bit 3 (formatter empty) is 0 while a word is held between input and RAM. In the cycle after the final word is accepted, done reads 1 and empty reads 0. One cycle later, empty reads 1.
- R9: A read of the RAM data register returns the word at the read pointer and then advances the read pointer by one modulo DEPTH. The read pointer can be written directly.
- R10: A control write that takes the enable bit from 0 to 1 clears the triggered and done flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_data | input | TRACE_W | Trace word |
| trace_valid | input | 1 | Trace word qualifier |
| trigger_in | input | 1 | Trigger event, sampled with a valid word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after the read strobe |
| sts_full | output | 1 | Write pointer has wrapped |
| sts_triggered | output | 1 | Trigger seen |
| sts_done | output | 1 | Acquisition complete |
| sts_fmt_empty | output | 1 | Holding stage empty |
| mode_demux | output | 1 | Demultiplexed port mode selected |

## Verification
The bench builds the block with DEPTH 16 and TRACE_W 16. The 16-entry buffer lets a 26-word capture wrap the write pointer in a few dozen cycles. The full flag, the wrap of the oldest-word address and the read-pointer wrap are each checked over one complete sweep of the RAM. With a 16-bit port, the demultiplexed-mode bit is exercised in its rejected form. The post-trigger count is run with the trigger early in the window and late in a wrapped window, and the one-cycle gap between done and formatter-empty is sampled at the exact cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int BUS_W = 32;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_DEPTH = 3'd2;
  localparam logic [2:0] RA_WIDTH = 3'd3;
  localparam logic [2:0] RA_RDPTR = 3'd4;
  localparam logic [2:0] RA_WRPTR = 3'd5;
  localparam logic [2:0] RA_TCNT  = 3'd6;
  localparam logic [2:0] RA_DATA  = 3'd7;

  // status word, bit 3 down to bit 0
  typedef struct packed {
    logic fmt_empty;
    logic done;
    logic triggered;
    logic full;
  } cap_status_t;
endpackage

// File: rtl/cap_fmt.sv
module cap_fmt #(
  parameter int W       = 16,
  parameter int ENTRIES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         empty
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = $clog2(ENTRIES + 1);

  logic [W-1:0]  slot [ENTRIES];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (count != '0);
  assign out_data  = slot[head];
  assign empty     = (count == '0);

  always_ff @(posedge clk) begin
    if (push) slot[tail] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push)      tail <= nxt(tail);
      if (out_valid) head <= nxt(head);
      count <= count + CW'(push) - CW'(out_valid);
    end
  end
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             en_rise,
  input  logic             trace_valid,
  input  logic             trigger_in,
  input  logic             store,
  input  logic             wrptr_we,
  input  logic [AW-1:0]    wrptr_wdata,
  input  logic             rdptr_we,
  input  logic [AW-1:0]    rdptr_wdata,
  input  logic             tcnt_we,
  input  logic [CNT_W-1:0] tcnt_wdata,
  input  logic             data_rd,
  output logic             accept,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] tcnt,
  output logic             full,
  output logic             triggered,
  output logic             done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign accept = en & trace_valid & ~done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      full      <= 1'b0;
      tcnt      <= '0;
      triggered <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (wrptr_we) begin
        wr_ptr <= wrptr_wdata;
        full   <= 1'b0;
      end else if (store) begin
        wr_ptr <= inc(wr_ptr);
        if (wr_ptr == LAST) full <= 1'b1;
      end

      if (rdptr_we)     rd_ptr <= rdptr_wdata;
      else if (data_rd) rd_ptr <= inc(rd_ptr);

      if (tcnt_we)
        tcnt <= tcnt_wdata;
      else if (accept && triggered && tcnt != '0)
        tcnt <= tcnt - 1'b1;

      if (en_rise) begin
        triggered <= 1'b0;
        done      <= 1'b0;
      end else if (accept) begin
        if (!triggered) begin
          if (trigger_in) begin
            triggered <= 1'b1;
            if (tcnt == '0) done <= 1'b1;
          end
        end else if (tcnt == CNT_W'(1)) begin
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cap_trace_buf.sv
module cap_trace_buf
  import cap_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRACE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TRACE_W-1:0] trace_data,
  input  logic               trace_valid,
  input  logic               trigger_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [2:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               sts_full,
  output logic               sts_triggered,
  output logic               sts_done,
  output logic               sts_fmt_empty,
  output logic               mode_demux
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = AW + 1;

  logic en_q, demux_q, demux_next;
  logic ctrl_wr, en_rise, wrptr_we, rdptr_we, tcnt_we, data_rd;
  logic fmt_push, fmt_pop;
  logic [TRACE_W-1:0] fmt_data, ram_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] tcnt;
  logic [BUS_W-1:0] reg_q;
  logic sel_ram_q;
  logic unused_wdata;
  cap_status_t status;

  assign unused_wdata = ^bus_wdata;

  assign ctrl_wr  = bus_wr && (bus_addr == RA_CTRL);
  assign wrptr_we = bus_wr && (bus_addr == RA_WRPTR);
  assign rdptr_we = bus_wr && (bus_addr == RA_RDPTR);
  assign tcnt_we  = bus_wr && (bus_addr == RA_TCNT);
  assign data_rd  = bus_rd && (bus_addr == RA_DATA);
  assign en_rise  = ctrl_wr && bus_wdata[0] && !en_q;

  generate
    if (TRACE_W == 8) begin : g_demux_ok
      assign demux_next = bus_wdata[1];
    end else begin : g_demux_no
      assign demux_next = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      demux_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q    <= bus_wdata[0];
      demux_q <= demux_next;
    end
  end
  assign mode_demux = demux_q;

  cap_fmt #(.W(TRACE_W), .ENTRIES(2)) u_fmt (
    .clk(clk), .rst(rst), .push(fmt_push), .din(trace_data),
    .out_valid(fmt_pop), .out_data(fmt_data), .empty(sts_fmt_empty)
  );

  cap_ram #(.W(TRACE_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(fmt_pop), .waddr(wr_ptr), .wdata(fmt_data),
    .raddr(rd_ptr), .rdata(ram_q)
  );

  cap_seq #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(en_q), .en_rise(en_rise),
    .trace_valid(trace_valid), .trigger_in(trigger_in), .store(fmt_pop),
    .wrptr_we(wrptr_we), .wrptr_wdata(bus_wdata[AW-1:0]),
    .rdptr_we(rdptr_we), .rdptr_wdata(bus_wdata[AW-1:0]),
    .tcnt_we(tcnt_we), .tcnt_wdata(bus_wdata[CNT_W-1:0]),
    .data_rd(data_rd), .accept(fmt_push),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .tcnt(tcnt),
    .full(sts_full), .triggered(sts_triggered), .done(sts_done)
  );

  assign status = '{fmt_empty: sts_fmt_empty, done: sts_done,
                    triggered: sts_triggered, full: sts_full};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_ram_q <= 1'b0;
    end else if (bus_rd) begin
      sel_ram_q <= (bus_addr == RA_DATA);
      case (bus_addr)
        RA_CTRL:  reg_q <= BUS_W'({demux_q, en_q});
        RA_STAT:  reg_q <= BUS_W'(status);
        RA_DEPTH: reg_q <= BUS_W'(DEPTH);
        RA_WIDTH: reg_q <= BUS_W'(TRACE_W);
        RA_RDPTR: reg_q <= BUS_W'(rd_ptr);
        RA_WRPTR: reg_q <= BUS_W'(wr_ptr);
        RA_TCNT:  reg_q <= BUS_W'(tcnt);
        default:  reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_ram_q ? BUS_W'(ram_q) : reg_q;
endmodule

// File: rtl/cap_trace_buf_chk.sv
module cap_trace_buf_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          fmt_push,
  input logic          fmt_pop,
  input logic          wrptr_we,
  input logic          rdptr_we,
  input logic          data_rd,
  input logic          ctrl_wr,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic          sts_full,
  input logic          sts_triggered,
  input logic          sts_done,
  input logic          sts_fmt_empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_WRPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    fmt_pop && !wrptr_we |=> wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1)); // R4

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    sts_full && !wrptr_we |=> sts_full); // R5

  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (rst)
    sts_triggered && !ctrl_wr |=> sts_triggered); // R6

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    sts_done && sts_fmt_empty && !wrptr_we && !ctrl_wr |=> $stable(wr_ptr)); // R7

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    sts_fmt_empty && !fmt_push |=> sts_fmt_empty); // R8

  AST_RDPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    data_rd && !rdptr_we |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1)); // R9
endmodule

bind cap_trace_buf cap_trace_buf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .fmt_push(fmt_push), .fmt_pop(fmt_pop),
  .wrptr_we(wrptr_we), .rdptr_we(rdptr_we), .data_rd(data_rd), .ctrl_wr(ctrl_wr),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .sts_full(sts_full),
  .sts_triggered(sts_triggered), .sts_done(sts_done), .sts_fmt_empty(sts_fmt_empty)
);

// File: tb/cap_trace_buf_bench.sv
module cap_trace_buf_bench;
  localparam int DEPTH   = 16;
  localparam int TRACE_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TRACE_W-1:0] trace_data = '0;
  logic trace_valid = 1'b0;
  logic trigger_in = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sts_full, sts_triggered, sts_done, sts_fmt_empty, mode_demux;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cap_trace_buf #(.DEPTH(DEPTH), .TRACE_W(TRACE_W)) u_cap_trace_buf (
    .clk(clk), .rst(rst), .trace_data(trace_data), .trace_valid(trace_valid),
    .trigger_in(trigger_in), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_full(sts_full),
    .sts_triggered(sts_triggered), .sts_done(sts_done),
    .sts_fmt_empty(sts_fmt_empty), .mode_demux(mode_demux)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // drive n words; trigger on word trig_at; check done/empty timing at done_at
  task automatic stream(input int n, input int trig_at, input int done_at,
                        input logic [TRACE_W-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == done_at - 1) chk(32'(sts_done), 32'd0, "R7 done not yet set");
      if (i == done_at) begin
        chk(32'(sts_done), 32'd1, "R7 done after last post-trigger word");
        chk(32'(sts_fmt_empty), 32'd0, "R8 formatter holds last word");
      end
      if (i == done_at + 1) chk(32'(sts_fmt_empty), 32'd1, "R8 formatter drained");
      trace_valid = 1'b1;
      trace_data  = base + TRACE_W'(i);
      trigger_in  = (i == trig_at);
    end
    @(negedge clk);
    trace_valid = 1'b0;
    trigger_in  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk({28'd0, sts_fmt_empty, sts_done, sts_triggered, sts_full}, 32'h8, "R1 status pins");
    bus_read(3'd1, d); chk(d, 32'h8, "R1 status reg");
    bus_read(3'd0, d); chk(d, 32'h0, "R1 ctrl reg");
    bus_read(3'd5, d); chk(d, 32'h0, "R1 write pointer");
    bus_read(3'd4, d); chk(d, 32'h0, "R1 read pointer");
    bus_read(3'd6, d); chk(d, 32'h0, "R1 trigger counter");
  endtask

  task automatic t_idregs();
    logic [31:0] d;
    bus_read(3'd2, d); chk(d, 32'(DEPTH), "R2 depth reg");
    bus_read(3'd3, d); chk(d, 32'(TRACE_W), "R2 width reg");
    bus_write(3'd2, 32'd99);
    bus_write(3'd3, 32'd77);
    bus_read(3'd2, d); chk(d, 32'(DEPTH), "R2 depth reg ignores write");
    bus_read(3'd3, d); chk(d, 32'(TRACE_W), "R2 width reg ignores write");
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bus_write(3'd0, 32'h3);
    bus_read(3'd0, d); chk(d, 32'h1, "R3 demux bit dropped for 16-bit port");
    chk(32'(mode_demux), 32'd0, "R3 demux pin");
    bus_write(3'd0, 32'h0);
    stream(3, 1, -10, 16'h5000);
    bus_read(3'd5, d); chk(d, 32'h0, "R3 disabled capture stores nothing");
    chk(32'(sts_triggered), 32'd0, "R3 disabled trigger ignored");
  endtask

  task automatic t_nowrap();
    logic [31:0] d;
    bus_write(3'd6, 32'd3);
    bus_write(3'd5, 32'd0);
    bus_write(3'd0, 32'h1);
    stream(12, 4, 8, 16'hA000);
    chk(32'(sts_triggered), 32'd1, "R6 triggered flag");
    chk(32'(sts_full), 32'd0, "R5 no wrap");
    bus_read(3'd5, d); chk(d, 32'd8, "R7 words kept = trigger word + 3");
    bus_read(3'd6, d); chk(d, 32'd0, "R7 counter exhausted");
    bus_write(3'd4, 32'd0);
    for (int j = 0; j < 8; j++) begin
      bus_read(3'd7, d); chk(d, 32'h0000A000 + 32'(j), "R4 R9 stored word");
    end
    bus_read(3'd4, d); chk(d, 32'd8, "R9 read pointer advanced");
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    bus_write(3'd0, 32'h0);
    bus_write(3'd5, 32'd0);
    bus_write(3'd6, 32'd5);
    bus_write(3'd0, 32'h1);
    chk(32'(sts_triggered), 32'd0, "R10 triggered cleared on enable");
    chk(32'(sts_done), 32'd0, "R10 done cleared on enable");
    stream(30, 20, 26, 16'hB000);
    chk(32'(sts_full), 32'd1, "R5 full after wrap");
    bus_read(3'd5, d); chk(d, 32'd10, "R4 write pointer modulo depth");
    bus_write(3'd4, 32'd10);
    for (int j = 0; j < DEPTH; j++) begin
      bus_read(3'd7, d); chk(d, 32'h0000B000 + 32'(10 + j), "R9 wrapped readout oldest first");
    end
    bus_read(3'd4, d); chk(d, 32'd10, "R9 read pointer wraps");
    bus_write(3'd5, 32'd0);
    chk(32'(sts_full), 32'd0, "R5 full cleared by pointer write");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idregs();
    t_ctrl();
    t_nowrap();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1-to-R10 run actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule